// File: doc/BRIEF.md
# Block-Transfer Host Register Interface

This block is the host-facing side of a block-transfer messaging channel between a host processor and a management controller. The host sees a three-byte register window: a handshake/status byte, a data port, and a read-only view of an interrupt mask byte. Bytes written to the data port are collected into a request buffer. Reads from the data port drain a response buffer that a downstream framer has filled and loaded.

The handshake byte has mixed write semantics. Some bits are cleared by writing one. One bit flips on each write of one. One bit is a doorbell: it marks the controller busy and sends a one-cycle request-ready event to the framer. The framer reads the request bytes and their count through a side port. It writes response bytes into the response buffer and loads a length, which raises the response-attention flag. Interrupt generation and message parsing live elsewhere. Writes to the mask offset are passed out unchanged to the interrupt logic.

Top module: `bt_host_regs`

## Requirements
- R1: The 2-bit address selects offset 0 = handshake byte, 1 = data port, 2 = mask status (the value on `mask_status`); offset 3 reads 0xFF and a write to it changes no state.
- R2: The handshake byte reads bit 7 = controller busy, bit 6 = host busy, bit 4 = management attention, bit 3 = response attention; bits 0, 1, 2 and 5 always read 0. After reset it reads 0x00, the request count is 0 and no response byte is pending.
- R3: Writing the handshake byte with bit 0 set makes the request count 0. Writing it with bit 1 set returns the response read position to the first byte.
- R4: Writing 1 to handshake bit 3 clears response attention, and writing 1 to bit 4 clears management attention; writing 0 to either bit leaves that flag unchanged.
- R5: Each write of the handshake byte with bit 6 set inverts the host-busy flag.
- R6: Writing the handshake byte with bit 2 set sets controller busy and raises `req_ready` for exactly the one cycle that follows the write.
- R7: A data-port write stores the byte at index `req_count` only while `req_count` is below CAP, and always increments `req_count`, which saturates at its all-ones value and never wraps.
- R8: A data-port read returns the response byte at the read position while that position is below the loaded length, then advances; on reaching the length, both the position and the length become 0. With no byte pending, the read returns 0xFF.
- R9: `rsp_load` sets the length to `rsp_len`, clamped to CAP, sets the read position to 0, sets response attention and clears controller busy. If a host clear of bit 3 happens in the same cycle, the load wins. If a doorbell happens in the same cycle, controller busy stays set.
- R10: `sms_set` sets management attention, and it wins over a host clear of bit 4 in the same cycle.
- R11: A write to offset 2 drives `mask_wr` high with `mask_wdata` equal to the written byte in that same cycle, and has no effect on the handshake byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| mask_status | input | 8 | Mask byte from the interrupt logic, read at offset 2 |
| mask_wr | output | 1 | Host wrote offset 2 this cycle |
| mask_wdata | output | 8 | Byte written to offset 2 |
| sms_set | input | 1 | Raise management attention |
| req_ready | output | 1 | One-cycle doorbell event to the framer |
| req_count | output | CW | Request bytes written since the last clear |
| req_rd_idx | input | IW | Framer read index into the request buffer |
| req_rd_byte | output | 8 | Request byte at `req_rd_idx` |
| rsp_fill_en | input | 1 | Framer writes one response byte |
| rsp_fill_idx | input | IW | Response buffer write index |
| rsp_fill_byte | input | 8 | Response byte to store |
| rsp_load | input | 1 | Framer commits a response of `rsp_len` bytes |
| rsp_len | input | LW | Response length |

## Verification
A wrong read position or length shows up on the very next data-port read. It appears as a repeated byte, a skipped byte, or 0xFF arriving early or late. The bench therefore checks every response byte in order, up to and past the last one. A flag register that has the wrong value appears at the next read of the handshake byte. A wrong priority between a framer event and a host clear in the same cycle also appears there. These collisions are driven in a single cycle and read back one cycle later. A request count that wraps or stops too early is visible on `req_count` right after the write. A misplaced store is visible through `req_rd_byte`.

// File: rtl/bt_host_pkg.sv
package bt_host_pkg;

    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_DATA = 2'd1,
        OFS_MASK = 2'd2,
        OFS_HOLE = 2'd3
    } bt_ofs_e;

    localparam int unsigned B_CLR_WR   = 0;
    localparam int unsigned B_CLR_RD   = 1;
    localparam int unsigned B_DOORBELL = 2;
    localparam int unsigned B_RSP_ATN  = 3;
    localparam int unsigned B_SMS_ATN  = 4;
    localparam int unsigned B_HBUSY    = 6;
    localparam int unsigned B_BBUSY    = 7;

    localparam logic [7:0] EMPTY_BYTE = 8'hFF;

    typedef struct packed {
        logic bbusy;
        logic hbusy;
        logic sms_atn;
        logic rsp_atn;
    } bt_flags_t;

    typedef struct packed {
        logic clr_wr;
        logic clr_rd;
        logic doorbell;
        logic ack_rsp;
        logic ack_sms;
        logic flip_hbusy;
    } bt_cmd_t;

    function automatic bt_cmd_t decode_cmd(input logic [7:0] b);
        bt_cmd_t c;
        c.clr_wr     = b[B_CLR_WR];
        c.clr_rd     = b[B_CLR_RD];
        c.doorbell   = b[B_DOORBELL];
        c.ack_rsp    = b[B_RSP_ATN];
        c.ack_sms    = b[B_SMS_ATN];
        c.flip_hbusy = b[B_HBUSY];
        return c;
    endfunction

    function automatic logic [7:0] pack_flags(input bt_flags_t f);
        logic [7:0] b;
        b            = 8'h00;
        b[B_BBUSY]   = f.bbusy;
        b[B_HBUSY]   = f.hbusy;
        b[B_SMS_ATN] = f.sms_atn;
        b[B_RSP_ATN] = f.rsp_atn;
        return b;
    endfunction

endpackage

// File: rtl/bt_ctrl_flags.sv
module bt_ctrl_flags
    import bt_host_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_wr,
    input  bt_cmd_t   cmd,
    input  logic      rsp_load,
    input  logic      sms_set,
    output bt_flags_t flags,
    output logic      req_ready
);

    bt_flags_t nxt;

    always_comb begin
        nxt = flags;
        if (ctrl_wr) begin
            if (cmd.ack_rsp)    nxt.rsp_atn = 1'b0;
            if (cmd.ack_sms)    nxt.sms_atn = 1'b0;
            if (cmd.flip_hbusy) nxt.hbusy   = ~flags.hbusy;
        end
        if (rsp_load) begin
            nxt.rsp_atn = 1'b1;
            nxt.bbusy   = 1'b0;
        end
        if (sms_set) nxt.sms_atn = 1'b1;
        if (ctrl_wr && cmd.doorbell) nxt.bbusy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            req_ready <= 1'b0;
        end else begin
            flags     <= nxt;
            req_ready <= ctrl_wr && cmd.doorbell;
        end
    end

    a_r6_ready_means_busy: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> flags.bbusy);

    a_r5_hbusy_flips: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && cmd.flip_hbusy) |=> (flags.hbusy != $past(flags.hbusy)));

    a_r10_sms_wins: assert property (@(posedge clk) disable iff (rst)
        sms_set |=> flags.sms_atn);

    a_r9_load_raises_atn: assert property (@(posedge clk) disable iff (rst)
        rsp_load |=> flags.rsp_atn);

endmodule

// File: rtl/bt_req_buf.sv
module bt_req_buf #(
    parameter int unsigned CAP = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [7:0]                    wdata,
    input  logic                          clr,
    input  logic [$clog2(CAP)-1:0]        rd_idx,
    output logic [7:0]                    rd_byte,
    output logic [$clog2(CAP+1):0]        count
);

    localparam int unsigned IW = $clog2(CAP);
    localparam int unsigned CW = $clog2(CAP + 1) + 1;

    logic [7:0] mem [CAP];
    logic       in_room;

    assign in_room = count < CW'(CAP);
    assign rd_byte = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en && in_room) mem[count[IW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (wr_en && (count != {CW{1'b1}})) begin
            count <= count + CW'(1);
        end
    end

    a_r7_count_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> count >= $past(count));

    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

endmodule

// File: rtl/bt_rsp_buf.sv
module bt_rsp_buf #(
    parameter int unsigned CAP = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fill_en,
    input  logic [$clog2(CAP)-1:0]    fill_idx,
    input  logic [7:0]                fill_byte,
    input  logic                      load,
    input  logic [$clog2(CAP+1)-1:0]  load_len,
    input  logic                      host_rd,
    input  logic                      clr_pos,
    output logic [7:0]                rd_byte
);

    import bt_host_pkg::*;

    localparam int unsigned IW = $clog2(CAP);
    localparam int unsigned LW = $clog2(CAP + 1);

    logic [7:0]    mem [CAP];
    logic [LW-1:0] pos_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] len_clamped;
    logic          pending;

    assign pending     = pos_q < len_q;
    assign len_clamped = (load_len > LW'(CAP)) ? LW'(CAP) : load_len;
    assign rd_byte     = pending ? mem[pos_q[IW-1:0]] : EMPTY_BYTE;

    always_ff @(posedge clk) begin
        if (fill_en) mem[fill_idx] <= fill_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            len_q <= '0;
        end else if (load) begin
            pos_q <= '0;
            len_q <= len_clamped;
        end else if (clr_pos) begin
            pos_q <= '0;
        end else if (host_rd && pending) begin
            if ((pos_q + LW'(1)) == len_q) begin
                pos_q <= '0;
                len_q <= '0;
            end else begin
                pos_q <= pos_q + LW'(1);
            end
        end
    end

    a_r8_pos_consistent: assert property (@(posedge clk) disable iff (rst)
        (pos_q < len_q) || (pos_q == '0));

    a_r9_len_capped: assert property (@(posedge clk) disable iff (rst)
        len_q <= LW'(CAP));

    a_r8_empty_reads_ff: assert property (@(posedge clk) disable iff (rst)
        !pending |-> rd_byte == EMPTY_BYTE);

endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
    import bt_host_pkg::*;
#(
    parameter int unsigned CAP = 64,
    localparam int unsigned IW = $clog2(CAP),
    localparam int unsigned LW = $clog2(CAP + 1),
    localparam int unsigned CW = $clog2(CAP + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [1:0]    host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [7:0]    mask_status,
    output logic          mask_wr,
    output logic [7:0]    mask_wdata,
    input  logic          sms_set,
    output logic          req_ready,
    output logic [CW-1:0] req_count,
    input  logic [IW-1:0] req_rd_idx,
    output logic [7:0]    req_rd_byte,
    input  logic          rsp_fill_en,
    input  logic [IW-1:0] rsp_fill_idx,
    input  logic [7:0]    rsp_fill_byte,
    input  logic          rsp_load,
    input  logic [LW-1:0] rsp_len
);

    bt_ofs_e   ofs;
    bt_cmd_t   cmd;
    bt_flags_t flags;
    logic      ctrl_wr;
    logic      data_wr;
    logic      data_rd;
    logic [7:0] rsp_byte;

    assign ofs        = bt_ofs_e'(host_addr);
    assign cmd        = decode_cmd(host_wdata);
    assign ctrl_wr    = host_wr && (ofs == OFS_CTRL);
    assign data_wr    = host_wr && (ofs == OFS_DATA);
    assign data_rd    = host_rd && (ofs == OFS_DATA);
    assign mask_wr    = host_wr && (ofs == OFS_MASK);
    assign mask_wdata = host_wdata;

    bt_ctrl_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .cmd       (cmd),
        .rsp_load  (rsp_load),
        .sms_set   (sms_set),
        .flags     (flags),
        .req_ready (req_ready)
    );

    bt_req_buf #(.CAP(CAP)) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr),
        .wdata   (host_wdata),
        .clr     (ctrl_wr && cmd.clr_wr),
        .rd_idx  (req_rd_idx),
        .rd_byte (req_rd_byte),
        .count   (req_count)
    );

    bt_rsp_buf #(.CAP(CAP)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (rsp_fill_en),
        .fill_idx  (rsp_fill_idx),
        .fill_byte (rsp_fill_byte),
        .load      (rsp_load),
        .load_len  (rsp_len),
        .host_rd   (data_rd),
        .clr_pos   (ctrl_wr && cmd.clr_rd),
        .rd_byte   (rsp_byte)
    );

    always_comb begin
        unique case (ofs)
            OFS_CTRL: host_rdata = pack_flags(flags);
            OFS_DATA: host_rdata = rsp_byte;
            OFS_MASK: host_rdata = mask_status;
            default:  host_rdata = EMPTY_BYTE;
        endcase
    end

    a_r1_hole_reads_ff: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 2'd3) |-> host_rdata == 8'hFF);

    a_r1_hole_write_inert: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd3 && !rsp_load && !sms_set) |=> $stable(req_count) && $stable(flags));

    a_r11_mask_no_flag_change: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && !rsp_load && !sms_set) |=> $stable(flags));

endmodule

// File: tb/test_bt_host_regs.sv
`timescale 1ns/100ps
module test_bt_host_regs;

    localparam int CAP = 64;
    localparam int IW  = $clog2(CAP);
    localparam int LW  = $clog2(CAP + 1);
    localparam int CW  = $clog2(CAP + 1) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [1:0]    host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic [7:0]    mask_status = 8'h5A;
    logic          mask_wr;
    logic [7:0]    mask_wdata;
    logic          sms_set = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_count;
    logic [IW-1:0] req_rd_idx = '0;
    logic [7:0]    req_rd_byte;
    logic          rsp_fill_en = 1'b0;
    logic [IW-1:0] rsp_fill_idx = '0;
    logic [7:0]    rsp_fill_byte = '0;
    logic          rsp_load = 1'b0;
    logic [LW-1:0] rsp_len = '0;

    int total = 0;
    int failed = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } rd_item_t;
    rd_item_t sb[$];

    always #2.5 clk = ~clk;

    bt_host_regs #(.CAP(CAP)) i_bt_host_regs (
        .clk(clk), .rst(rst),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mask_status(mask_status), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .sms_set(sms_set), .req_ready(req_ready), .req_count(req_count),
        .req_rd_idx(req_rd_idx), .req_rd_byte(req_rd_byte),
        .rsp_fill_en(rsp_fill_en), .rsp_fill_idx(rsp_fill_idx),
        .rsp_fill_byte(rsp_fill_byte), .rsp_load(rsp_load), .rsp_len(rsp_len)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: compares each host read against the scoreboard
    always @(negedge clk) begin
        if (host_rd) begin
            total++;
            if (sb.size() == 0) begin
                failed++;
                $display("FAIL scoreboard: got 0x%0h expected none", host_rdata);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                if (host_rdata !== it.exp) begin
                    failed++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", it.req, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        rd_item_t it;
        it.exp = exp; it.req = req;
        sb.push_back(it);
        host_rd = 1'b1; host_addr = a;
        step();
        host_rd = 1'b0;
    endtask

    task automatic fill(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rsp_fill_en = 1'b1; rsp_fill_idx = IW'(i); rsp_fill_byte = base + 8'(i);
            step();
        end
        rsp_fill_en = 1'b0;
    endtask

    task automatic load(input int n);
        rsp_load = 1'b1; rsp_len = LW'(n);
        step();
        rsp_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state, R1 decode
        rd(2'd0, 8'h00, "R2 reset ctrl");
        rd(2'd1, 8'hFF, "R2 reset data empty");
        rd(2'd3, 8'hFF, "R1 hole read");
        rd(2'd2, 8'h5A, "R1 mask status read");
        chk("R2 reset count", int'(req_count), 0);
        chk("R2 reset ready", int'(req_ready), 0);

        // R7 request writes
        wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
        chk("R7 count after 3", int'(req_count), 3);
        req_rd_idx = IW'(1); #1;
        chk("R7 stored byte idx1", int'(req_rd_byte), 8'h22);

        // R6 doorbell
        wr(2'd0, 8'h04);
        chk("R6 ready pulse", int'(req_ready), 1);
        rd(2'd0, 8'h80, "R6 busy set");
        chk("R6 ready one cycle", int'(req_ready), 0);

        // R5 host busy toggle
        wr(2'd0, 8'h40);
        rd(2'd0, 8'hC0, "R5 toggle on");
        wr(2'd0, 8'h40);
        rd(2'd0, 8'h80, "R5 toggle off");

        // R9 load, R8 drain
        fill(3, 8'hA0);
        load(3);
        rd(2'd0, 8'h08, "R9 load sets atn clears busy");
        rd(2'd1, 8'hA0, "R8 byte0");
        rd(2'd1, 8'hA1, "R8 byte1");
        rd(2'd1, 8'hA2, "R8 byte2");
        rd(2'd1, 8'hFF, "R8 past end");

        // R4 write-one-to-clear
        wr(2'd0, 8'h00);
        rd(2'd0, 8'h08, "R4 zero leaves atn");
        wr(2'd0, 8'h08);
        rd(2'd0, 8'h00, "R4 rsp atn cleared");
        sms_set = 1'b1; step(); sms_set = 1'b0;
        rd(2'd0, 8'h10, "R10 sms set");
        wr(2'd0, 8'h10);
        rd(2'd0, 8'h00, "R4 sms atn cleared");

        // R3 rewind read position
        load(3);
        rd(2'd1, 8'hA0, "R3 first read");
        wr(2'd0, 8'h02);
        rd(2'd1, 8'hA0, "R3 rewound byte0");
        rd(2'd1, 8'hA1, "R3 rewound byte1");
        rd(2'd1, 8'hA2, "R3 rewound byte2");
        rd(2'd1, 8'hFF, "R3 rewound end");
        wr(2'd0, 8'h08);

        // R3 clear count, R2 unused bits read 0
        wr(2'd0, 8'h23);
        chk("R3 count cleared", int'(req_count), 0);
        rd(2'd0, 8'h00, "R2 unused bits read zero");

        // R7 overrun
        for (int i = 0; i < CAP + 2; i++) wr(2'd1, 8'(i));
        chk("R7 count past capacity", int'(req_count), CAP + 2);
        req_rd_idx = IW'(0); #1;
        chk("R7 idx0 kept", int'(req_rd_byte), 0);
        req_rd_idx = IW'(CAP - 1); #1;
        chk("R7 last slot", int'(req_rd_byte), CAP - 1);

        // R1 hole write inert
        wr(2'd3, 8'hFF);
        rd(2'd0, 8'h00, "R1 hole write no flag");
        chk("R1 hole write no count", int'(req_count), CAP + 2);

        // R11 mask write forwarded
        host_wr = 1'b1; host_addr = 2'd2; host_wdata = 8'h3C; #1;
        chk("R11 mask_wr high", int'(mask_wr), 1);
        chk("R11 mask data", int'(mask_wdata), 8'h3C);
        step(); host_wr = 1'b0; #0.1;
        chk("R11 mask_wr low", int'(mask_wr), 0);
        rd(2'd0, 8'h00, "R11 ctrl untouched");

        // R9 load wins over ack in same cycle
        host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h08;
        rsp_load = 1'b1; rsp_len = LW'(2);
        step();
        host_wr = 1'b0; rsp_load = 1'b0;
        rd(2'd0, 8'h08, "R9 load beats ack");
        rd(2'd1, 8'hA0, "R9 collided load byte0");
        rd(2'd1, 8'hA1, "R9 collided load byte1");
        rd(2'd1, 8'hFF, "R9 collided load end");

        // R10 set wins over clear
        host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h10; sms_set = 1'b1;
        step();
        host_wr = 1'b0; sms_set = 1'b0;
        rd(2'd0, 8'h18, "R10 set beats clear");
        wr(2'd0, 8'h18);
        rd(2'd0, 8'h00, "R4 both cleared");

        // R9 clamp to capacity
        fill(CAP, 8'h40);
        load(100);
        for (int i = 0; i < CAP; i++) rd(2'd1, 8'h40 + 8'(i), "R9 clamped drain");
        rd(2'd1, 8'hFF, "R9 clamped end");
        wr(2'd0, 8'h08);

        // R9 doorbell with load keeps busy, zero length
        host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h04;
        rsp_load = 1'b1; rsp_len = '0;
        step();
        host_wr = 1'b0; rsp_load = 1'b0;
        rd(2'd0, 8'h88, "R9 doorbell keeps busy");
        rd(2'd1, 8'hFF, "R8 zero length empty");

        step();
        chk("scoreboard drained", sb.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule